// File: doc/BRIEF.md
# USB Device Address Filter

This block keeps the device address that a USB function answers to and decides, for every decoded token, whether that token is meant for this device. Firmware hands the block a new address in one register write and switches it on in a second, later write, once the zero-length status stage of the address request has gone out. Until the second write lands, the block keeps filtering on address 0, so the status stage of the request still completes on the old address.

The stored address and its enable are wiped by an asynchronous hardware reset. They are also wiped in every cycle in which the controller is switched off, and on a bus reset strobe. The token side is a plain strobe with no back-pressure. Every token presented with `tok_valid` gets exactly one decision on the following clock, and a token may be presented on every cycle. The effective address is exported so that neighbouring logic can see which address is being matched.

Top module: `usb_addr_filter`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `eff_addr` is 0 and `dec_valid` and `dec_accept` are 0.
- R2: A write with the enable bit (`wr_data[7]`) at 0 stores `wr_data[6:0]` as the address and clears the enable. `eff_addr` is 0 on the next clock.
- R3: A write with the enable bit at 1 whose field `wr_data[6:0]` equals the stored address sets the enable. From the next clock, `eff_addr` equals the stored address.
- R4: A write with the enable bit at 1 whose field differs from the stored address is dropped. It changes neither the stored address nor the enable, so an address and its enable cannot be set in one write.
- R5: In every clock where `ctrl_en` is 0, the address and the enable are cleared, and any write in that cycle is lost. `eff_addr` is 0 on the next clock.
- R6: A clock with `bus_reset` at 1 clears the address and the enable. A write in the same cycle is lost.
- R7: `eff_addr` is 0 whenever the enable is clear or the stored address is 0. Otherwise it is the stored address.
- R8: On the clock after `tok_valid` is 1, `dec_valid` is 1 and `dec_accept` is 1 exactly when `tok_addr` equalled `eff_addr` in the strobe cycle. On the clock after `tok_valid` is 0, both are 0.
- R9: Bits `wr_data[15:8]` have no effect on any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ctrl_en | input | 1 | Controller enable; 0 holds the address cleared |
| bus_reset | input | 1 | One-cycle strobe: USB bus reset detected |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data: [6:0] address field, [7] enable bit, [15:8] ignored |
| tok_valid | input | 1 | Decoded token present this cycle |
| tok_addr | input | 7 | Address field of the token |
| dec_valid | output | 1 | Decision present (one clock after `tok_valid`) |
| dec_accept | output | 1 | Token was addressed to this device |
| eff_addr | output | 7 | Address currently used for matching |

## Verification
Tokens are sent for address 0, for the stored address, and for a neighbouring address. Each pattern is tried before arming, after arming, and after each kind of clear. This tells apart a filter that matches the stored field from one that matches the effective address. Writes are tried with the address only, with the enable and a matching field, with the enable and a different field, and with junk in the upper byte. These show that arming needs two writes and that the upper bits are inert. Writes that coincide with a bus reset or a disabled controller show which of the two wins.

// File: rtl/usbaf_pkg.sv
package usbaf_pkg;
  // Classification of one register write against the stored state
  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,  // no write this cycle
    WR_STORE = 2'd1,  // enable bit clear: load address, disarm
    WR_ARM   = 2'd2,  // enable bit set, field matches stored address
    WR_DROP  = 2'd3   // enable bit set, field differs: ignored
  } wr_kind_e;
endpackage

// File: rtl/usbaf_addr_store.sv
module usbaf_addr_store
  import usbaf_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int EN_POS = ADDR_W;

  logic [ADDR_W-1:0] addr_q;
  logic              on_q;
  logic [ADDR_W-1:0] field;
  logic              en_bit;
  wr_kind_e          kind;
  logic              unused_hi;

  assign field  = wr_data[ADDR_W-1:0];
  assign en_bit = wr_data[EN_POS];

  generate
    if (DATA_W > EN_POS + 1) begin : g_hi
      assign unused_hi = ^wr_data[DATA_W-1:EN_POS+1];
    end else begin : g_nohi
      assign unused_hi = 1'b0;
    end
  endgenerate

  always_comb begin
    kind = WR_NONE;
    if (wr_en) begin
      if (!en_bit)              kind = WR_STORE;
      else if (field == addr_q) kind = WR_ARM;
      else                      kind = WR_DROP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      on_q   <= 1'b0;
    end else if (clr) begin
      addr_q <= '0;
      on_q   <= 1'b0;
    end else begin
      case (kind)
        WR_STORE: begin
          addr_q <= field;
          on_q   <= 1'b0;
        end
        WR_ARM:  on_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign eff_addr = on_q ? addr_q : '0;
endmodule

// File: rtl/usbaf_token_match.sv
module usbaf_token_match #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [ADDR_W-1:0] eff_addr,
  output logic              dec_valid,
  output logic              dec_accept
);
  logic hit;
  assign hit = (tok_addr == eff_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= tok_valid;
      dec_accept <= tok_valid & hit;
    end
  end
endmodule

// File: rtl/usb_addr_filter.sv
module usb_addr_filter #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic              bus_reset,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tok_valid,
  input  logic [ADDR_W-1:0] tok_addr,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [ADDR_W-1:0] eff_addr
);
  logic clr;
  assign clr = ~ctrl_en | bus_reset;

  usbaf_addr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .eff_addr (eff_addr)
  );

  usbaf_token_match #(.ADDR_W(ADDR_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_valid  (tok_valid),
    .tok_addr   (tok_addr),
    .eff_addr   (eff_addr),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept)
  );
endmodule

// File: rtl/usb_addr_filter_chk.sv
module usb_addr_filter_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_en,
  input logic              bus_reset,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              tok_valid,
  input logic [ADDR_W-1:0] tok_addr,
  input logic              dec_valid,
  input logic              dec_accept,
  input logic [ADDR_W-1:0] eff_addr,
  input logic [ADDR_W-1:0] stored
);
  // R2: an address-only write leaves matching on address 0
  a_r2_store_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[ADDR_W]) |=> (eff_addr == '0));

  // R3: arming with the matching field exposes the stored address
  a_r3_arm_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[ADDR_W] && wr_data[ADDR_W-1:0] == stored && ctrl_en && !bus_reset)
    |=> (eff_addr == $past(stored)));

  // R4: arming with a different field changes nothing
  a_r4_combined_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[ADDR_W] && wr_data[ADDR_W-1:0] != stored && ctrl_en && !bus_reset)
    |=> $stable(eff_addr));

  // R5: disabled controller clears the address
  a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (eff_addr == '0));

  // R6: bus reset clears the address
  a_r6_busreset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (eff_addr == '0));

  // R8: one decision per token, one clock later
  a_r8_dec_follows: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> dec_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> (!dec_valid && !dec_accept));
  a_r8_accept_match: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> (dec_accept == ($past(tok_addr) == $past(eff_addr))));
endmodule

bind usb_addr_filter usb_addr_filter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_en    (ctrl_en),
  .bus_reset  (bus_reset),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .tok_valid  (tok_valid),
  .tok_addr   (tok_addr),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .eff_addr   (eff_addr),
  .stored     (u_store.addr_q)
);

// File: tb/sim_usb_addr_filter.sv
module sim_usb_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_en = 1'b1;
  logic        bus_reset = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tok_valid = 1'b0;
  logic [6:0]  tok_addr = '0;
  logic        dec_valid, dec_accept;
  logic [6:0]  eff_addr;

  int checks = 0;
  int failures = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  usb_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .bus_reset(bus_reset),
    .wr_en(wr_en), .wr_data(wr_data), .tok_valid(tok_valid), .tok_addr(tok_addr),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .eff_addr(eff_addr)
  );

  // Behavioural reference model
  int m_addr = 0;
  bit m_armed = 0;
  bit m_dv = 0;
  bit m_acc = 0;

  function automatic int m_eff();
    return m_armed ? m_addr : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr <= 0; m_armed <= 0; m_dv <= 0; m_acc <= 0;
    end else begin
      m_dv  <= tok_valid;
      m_acc <= tok_valid && (int'(tok_addr) == m_eff());
      if (!ctrl_en || bus_reset) begin
        m_addr <= 0; m_armed <= 0;
      end else if (wr_en) begin
        if (!wr_data[7]) begin
          m_addr <= int'(wr_data[6:0]); m_armed <= 0;
        end else if (int'(wr_data[6:0]) == m_addr) begin
          m_armed <= 1;
        end
      end
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  // Advance one clock and compare all outputs with the model away from the edge
  task automatic tick();
    @(negedge clk);
    chk(phase, "eff_addr", int'(eff_addr), m_eff());
    chk(phase, "dec_valid", int'(dec_valid), int'(m_dv));
    chk(phase, "dec_accept", int'(dec_accept), int'(m_acc));
  endtask

  task automatic wr(logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic tok(logic [6:0] a, int exp_acc);
    tok_valid = 1'b1; tok_addr = a;
    tick();
    tok_valid = 1'b0;
    chk(phase, "dec_accept fixed", int'(dec_accept), exp_acc);
  endtask

  initial begin
    #100_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    phase = "R1";
    repeat (3) tick();
    chk("R1", "eff_addr in reset", int'(eff_addr), 0);
    rst_n = 1'b1;
    tick();
    chk("R1", "dec_valid after reset", int'(dec_valid), 0);

    phase = "R2";
    wr(16'h002A);
    chk("R2", "eff_addr after store", int'(eff_addr), 0);
    phase = "R7";
    tok(7'h00, 1);
    tok(7'h2A, 0);

    phase = "R4";
    wr(16'h0095);  // enable set, field 0x15 differs from stored 0x2A
    chk("R4", "eff_addr after combined write", int'(eff_addr), 0);
    tok(7'h15, 0);

    phase = "R3";
    wr(16'h00AA);  // enable set, field 0x2A matches
    chk("R3", "eff_addr after arm", int'(eff_addr), 8'h2A);
    phase = "R8";
    tok(7'h2A, 1);
    tok(7'h00, 0);
    tok(7'h2B, 0);
    tok_valid = 1'b1; tok_addr = 7'h2A; tick();
    tok_addr = 7'h29; tick();
    tok_addr = 7'h2A; tick();
    tok_valid = 1'b0; tick();
    chk("R8", "dec_valid idle", int'(dec_valid), 0);

    phase = "R4";
    wr(16'h0091);  // different field while armed: dropped
    chk("R4", "armed address kept", int'(eff_addr), 8'h2A);

    phase = "R9";
    wr(16'hFF33);  // upper byte junk, enable clear, field 0x33
    chk("R9", "store ignores upper bits", int'(eff_addr), 0);
    wr(16'h5AB3);  // upper byte junk, enable set, field 0x33
    chk("R9", "arm ignores upper bits", int'(eff_addr), 8'h33);
    tok(7'h33, 1);

    phase = "R6";
    bus_reset = 1'b1; wr_en = 1'b1; wr_data = 16'h0044;
    tick();
    bus_reset = 1'b0; wr_en = 1'b0;
    chk("R6", "bus reset clears", int'(eff_addr), 0);
    wr(16'h00C4);  // arm 0x44 would succeed only if the write had landed
    chk("R6", "write lost under bus reset", int'(eff_addr), 0);
    tok(7'h00, 1);

    phase = "R5";
    wr(16'h0010);
    wr(16'h0090);
    chk("R5", "armed 0x10", int'(eff_addr), 8'h10);
    ctrl_en = 1'b0;
    wr(16'h0020);
    chk("R5", "disabled clears", int'(eff_addr), 0);
    ctrl_en = 1'b1;
    wr(16'h00A0);  // arm 0x20 fails since the store was lost
    chk("R5", "write lost while disabled", int'(eff_addr), 0);
    tok(7'h10, 0);

    phase = "R7";
    wr(16'h0000);
    wr(16'h0080);  // armed with address 0
    chk("R7", "armed zero address", int'(eff_addr), 0);
    tok(7'h00, 1);

    phase = "R1";
    wr(16'h0055);
    wr(16'h00D5);
    #2 rst_n = 1'b0;
    #1 chk("R1", "async reset clears", int'(eff_addr), 0);
    tick();
    rst_n = 1'b1;
    tick();
    tok(7'h55, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule